// File: doc/BRIEF.md
# Scanline and Vertical-Blank Sequencer

This block turns the system clock into frame timing for a video subsystem. A fractional phase accumulator sets the length of each horizontal line. Every line adds a fixed step, held in units of 1/4096 clock, to a 12-bit remainder. The integer part of that sum is the number of clocks in the next line, and the low 12 bits carry over to the line after it. The result is an average line length that need not be a whole number of clocks, with no drift over time.

A line counter runs over two phases. In the active phase it counts up to a fixed vertical-blank line. When it reaches that line it does five things in the same clock:
- raises the vblank interrupt;
- emits a blank-start pulse;
- clears the line-change flag;
- restarts the line count from zero;
- advances the frame counter.

In the blank phase it counts the remaining lines of the frame. Those are the lines in the frame total that follow the vblank line, and the total depends on the captured standard: 263 lines for 60 Hz, 313 lines for 50 Hz. When the blank phase ends, the frame wraps: the block emits a blank-end pulse and captures the standard-select input for the next frame. A field-parity bit follows the frame count only when both interlace control bits are set. A separate tick fires every 32 lines, whatever the frame position.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake and no back-pressure. Event outputs are single-clock pulses and are not held.

Top module: `scanline_sequencer`

## Requirements
- R1: Line length. After reset the remainder is 0. For each line, sum = remainder + LINE_STEP; the line lasts sum>>12 clocks and the new remainder is sum mod 4096. `line_tick_o` is high during the last clock of each line. The first line ends in the (LINE_STEP>>12)-th clock after reset is released. LINE_STEP must be at least 4096.
- R2: Frame length. With `std_sel_i` = 0 captured, a frame spans 263 line ticks; with 1 captured, it spans 313.
- R3: Vblank start. On the line tick that brings the active-phase count to 240, `blank_start_o` and `vblank_irq_o` are both high for exactly one clock, starting the clock after that tick.
- R4: Line count. `line_cnt_o` counts line ticks from 0 within each phase. It returns to 0 when the vblank line is reached and again at frame wrap. `in_vblank_o` is 1 during the blank phase.
- R5: Frame count. `frame_cnt_o` (FRAME_W bits, wrapping) increases by one in the same clock that the vblank pulse appears.
- R6: Line-change flag. `line_flag_o` toggles on every line tick, except on the vblank tick, which forces it to 0.
- R7: Field bit. On the vblank tick, `field_o` loads bit 0 of the new frame count if `ilace_i` == 2'b11, and 0 otherwise. Between vblank ticks it holds its value.
- R8: Standard capture. `std_sel_i` is captured only while reset is held and on the frame-wrap tick. A change in mid-frame does not alter the length of the current frame.
- R9: Vblank end. On the line tick that ends the blank phase, `blank_end_o` is high for one clock, starting the next clock, and the phase returns to active.
- R10: Periodic tick. `aux_tick_o` pulses for one clock after every 32nd line tick. It counts continuously across frames and is cleared only by reset.
- R11: Reset. A synchronous reset (`rst_i` high at a clock edge) clears the remainder, the line count, the phase, the frame counter, the field bit, the flag and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| std_sel_i | input | 1 | Line-total select: 0 = 263 lines, 1 = 313 lines |
| ilace_i | input | 2 | Interlace control; both bits set enables the field bit |
| line_tick_o | output | 1 | High during the last clock of each line |
| line_cnt_o | output | LINE_W (9) | Line count within the current phase |
| in_vblank_o | output | 1 | High during the blank phase |
| blank_start_o | output | 1 | One-clock pulse at vblank start |
| blank_end_o | output | 1 | One-clock pulse at frame wrap |
| vblank_irq_o | output | 1 | Vblank interrupt pulse (interrupt bit 0) |
| frame_cnt_o | output | FRAME_W (16) | Frame counter |
| field_o | output | 1 | Odd/even field status |
| line_flag_o | output | 1 | Line-change status flag |
| aux_tick_o | output | 1 | Pulse once every 32 lines |

## Verification
The bench targets the remainder carry-over between lines. A design that dropped the fraction, or reloaded it from zero, would drift by a clock within a few lines, and the per-clock tick comparison would catch it. The standard select is toggled randomly in mid-frame. A design that used the live input instead of the value captured at wrap would end the frame after the wrong number of ticks. The interlace bits are varied so that a design that accepts a single set bit, or that takes parity from the old frame count, shows a wrong field bit. Resets are also placed mid-frame, and a design that kept any counter across reset would show it in the cleared state.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;
  localparam int FRAC_W = 12;

  typedef enum logic {
    PH_ACTIVE = 1'b0,
    PH_BLANK  = 1'b1
  } phase_e;

  typedef struct packed {
    logic vbl;
    logic wrap;
  } seq_evt_t;
endpackage

// File: rtl/line_phase_gen.sv
module line_phase_gen
  import scanseq_pkg::*;
#(
  parameter int LINE_STEP = 8791293
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int ACC_W   = $clog2(LINE_STEP + (1 << FRAC_W)) + 1;
  localparam int PER_MAX = (LINE_STEP + (1 << FRAC_W) - 1) >> FRAC_W;
  localparam int CNT_W   = $clog2(PER_MAX + 1);
  localparam int PER_MIN = LINE_STEP >> FRAC_W;

  logic [FRAC_W-1:0] frac_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  sum_w;
  logic [ACC_W-1:0]  per_w;
  logic [ACC_W-1:0]  first_w;

  always_comb begin
    sum_w   = ACC_W'(frac_q) + ACC_W'(LINE_STEP);
    per_w   = sum_w >> FRAC_W;
    first_w = ACC_W'(LINE_STEP);
  end

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frac_q <= first_w[FRAC_W-1:0];
      cnt_q  <= CNT_W'(PER_MIN - 1);
    end else if (tick_o) begin
      frac_q <= sum_w[FRAC_W-1:0];
      cnt_q  <= CNT_W'(per_w - ACC_W'(1));
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  AST_COUNTDOWN: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R1
  AST_RELOAD_MIN: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> (32'(cnt_q) >= PER_MIN - 1)); // R1
endmodule

// File: rtl/line_sequencer.sv
module line_sequencer
  import scanseq_pkg::*;
#(
  parameter int LINES_60 = 263,
  parameter int LINES_50 = 313,
  parameter int VBL_LINE = 240,
  parameter int LINE_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              std_sel_i,
  output seq_evt_t          evt_o,
  output logic [LINE_W-1:0] line_o,
  output logic              blank_o,
  output logic              blank_start_o,
  output logic              blank_end_o
);
  phase_e            phase_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_inc;
  logic [LINE_W-1:0] blank_lines;
  logic              std_q;
  logic              bs_q;
  logic              be_q;
  logic              seen_q;

  always_comb begin
    line_inc    = line_q + LINE_W'(1);
    blank_lines = std_q ? LINE_W'(LINES_50 - VBL_LINE) : LINE_W'(LINES_60 - VBL_LINE);
    evt_o.vbl   = tick_i && (phase_q == PH_ACTIVE) && (line_inc == LINE_W'(VBL_LINE));
    evt_o.wrap  = tick_i && (phase_q == PH_BLANK) && (line_inc == blank_lines);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_ACTIVE;
      line_q  <= '0;
      std_q   <= std_sel_i;
      bs_q    <= 1'b0;
      be_q    <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      bs_q   <= evt_o.vbl;
      be_q   <= evt_o.wrap;
      if (evt_o.vbl) begin
        phase_q <= PH_BLANK;
        line_q  <= '0;
      end else if (evt_o.wrap) begin
        phase_q <= PH_ACTIVE;
        line_q  <= '0;
        std_q   <= std_sel_i;
      end else if (tick_i) begin
        line_q  <= line_inc;
      end
    end
  end

  assign line_o        = line_q;
  assign blank_o       = (phase_q == PH_BLANK);
  assign blank_start_o = bs_q;
  assign blank_end_o   = be_q;

  AST_VBL_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen_q && $rose(blank_o)) |-> bs_q); // R3
  AST_ACTIVE_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_ACTIVE) |-> (32'(line_q) < VBL_LINE)); // R4
  AST_STD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen_q && !be_q) |-> $stable(std_q)); // R8
  AST_END_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
    be_q |-> (phase_q == PH_ACTIVE && line_q == '0)); // R9
endmodule

// File: rtl/frame_status.sv
module frame_status
  import scanseq_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               tick_i,
  input  seq_evt_t           evt_i,
  input  logic [1:0]         ilace_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               field_o,
  output logic               lflag_o,
  output logic               irq_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_inc;
  logic               field_q;
  logic               lflag_q;
  logic               irq_q;
  logic               seen_q;

  assign frame_inc = frame_q + FRAME_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frame_q <= '0;
      field_q <= 1'b0;
      lflag_q <= 1'b0;
      irq_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      irq_q  <= evt_i.vbl;
      if (evt_i.vbl) begin
        frame_q <= frame_inc;
        field_q <= (ilace_i == 2'b11) && frame_inc[0];
        lflag_q <= 1'b0;
      end else if (tick_i) begin
        lflag_q <= ~lflag_q;
      end
    end
  end

  assign frame_o = frame_q;
  assign field_o = field_q;
  assign lflag_o = lflag_q;
  assign irq_o   = irq_q;

  AST_FRAME_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> (frame_q == FRAME_W'($past(frame_q) + FRAME_W'(1)))); // R5
  AST_LFLAG_CLR: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> !lflag_q); // R6
  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen_q && !irq_q) |-> $stable(field_q)); // R7
endmodule

// File: rtl/aux_tick_div.sv
module aux_tick_div #(
  parameter int DIV = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          last_w;
  logic          pulse_q;

  assign last_w = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick_i && last_w;
      if (tick_i) cnt_q <= last_w ? '0 : cnt_q + CW'(1);
    end
  end

  assign pulse_o = pulse_q;

  AST_AUX_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_q |-> (cnt_q == '0)); // R10
endmodule

// File: rtl/scanline_sequencer.sv
module scanline_sequencer
  import scanseq_pkg::*;
#(
  parameter int LINE_STEP = 8791293,
  parameter int LINES_60  = 263,
  parameter int LINES_50  = 313,
  parameter int VBL_LINE  = 240,
  parameter int AUX_DIV   = 32,
  parameter int FRAME_W   = 16,
  localparam int LINE_W   = $clog2(((LINES_60 > LINES_50) ? LINES_60 : LINES_50) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               std_sel_i,
  input  logic [1:0]         ilace_i,
  output logic               line_tick_o,
  output logic [LINE_W-1:0]  line_cnt_o,
  output logic               in_vblank_o,
  output logic               blank_start_o,
  output logic               blank_end_o,
  output logic               vblank_irq_o,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic               field_o,
  output logic               line_flag_o,
  output logic               aux_tick_o
);
  logic     tick_w;
  seq_evt_t evt_w;

  line_phase_gen #(.LINE_STEP(LINE_STEP)) u_phase (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tick_o(tick_w)
  );

  line_sequencer #(
    .LINES_60(LINES_60),
    .LINES_50(LINES_50),
    .VBL_LINE(VBL_LINE),
    .LINE_W  (LINE_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .tick_i       (tick_w),
    .std_sel_i    (std_sel_i),
    .evt_o        (evt_w),
    .line_o       (line_cnt_o),
    .blank_o      (in_vblank_o),
    .blank_start_o(blank_start_o),
    .blank_end_o  (blank_end_o)
  );

  frame_status #(.FRAME_W(FRAME_W)) u_status (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick_w),
    .evt_i  (evt_w),
    .ilace_i(ilace_i),
    .frame_o(frame_cnt_o),
    .field_o(field_o),
    .lflag_o(line_flag_o),
    .irq_o  (vblank_irq_o)
  );

  aux_tick_div #(.DIV(AUX_DIV)) u_aux (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick_w),
    .pulse_o(aux_tick_o)
  );

  assign line_tick_o = tick_w;

  AST_IRQ_WITH_START: assert property (@(posedge clk_i) disable iff (rst_i)
    vblank_irq_o == blank_start_o); // R3
endmodule

// File: tb/scanline_sequencer_tb_top.sv
module scanline_sequencer_tb_top;
  localparam int STEP = 2 * 4096 + 1500;
  localparam int VBL  = 240;
  localparam int FW   = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        std_sel;
  logic [1:0]  ilace;
  logic        line_tick;
  logic [8:0]  line_cnt;
  logic        in_vblank, blank_start, blank_end, irq;
  logic [FW-1:0] frame_cnt;
  logic        field, lflag, aux;

  always #2.5 clk = ~clk;

  scanline_sequencer #(.LINE_STEP(STEP)) dut_i (
    .clk_i(clk), .rst_i(rst), .std_sel_i(std_sel), .ilace_i(ilace),
    .line_tick_o(line_tick), .line_cnt_o(line_cnt), .in_vblank_o(in_vblank),
    .blank_start_o(blank_start), .blank_end_o(blank_end), .vblank_irq_o(irq),
    .frame_cnt_o(frame_cnt), .field_o(field), .line_flag_o(lflag), .aux_tick_o(aux)
  );

  int errors = 0;
  int checks = 0;

  // reference state
  int m_frac, m_cnt, m_line, m_blank, m_std, m_frame, m_field, m_lflag, m_aux_cnt;
  int m_bs, m_be, m_auxp;
  int ticks_seen, frame_std;

  function automatic int frame_total(int s);
    return s ? 313 : 263;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int tk, sum, vbl, wrap;
    if (rst) begin
      m_frac = STEP % 4096; m_cnt = STEP / 4096 - 1;
      m_line = 0; m_blank = 0; m_std = std_sel; m_frame = 0; m_field = 0;
      m_lflag = 0; m_aux_cnt = 0; m_bs = 0; m_be = 0; m_auxp = 0;
    end else begin
      tk = (m_cnt == 0);
      vbl = 0; wrap = 0;
      if (tk) begin
        sum = m_frac + STEP;
        m_cnt = sum / 4096 - 1;
        m_frac = sum % 4096;
      end else m_cnt = m_cnt - 1;
      if (tk) begin
        if (!m_blank) begin
          if (m_line + 1 == VBL) begin vbl = 1; m_line = 0; m_blank = 1; end
          else m_line = m_line + 1;
        end else begin
          if (m_line + 1 == frame_total(m_std) - VBL) begin
            wrap = 1; m_line = 0; m_blank = 0; m_std = std_sel;
          end else m_line = m_line + 1;
        end
      end
      m_bs = vbl; m_be = wrap;
      if (vbl) begin
        m_frame = (m_frame + 1) % (1 << FW);
        m_field = (ilace == 2'b11) ? (m_frame & 1) : 0;
        m_lflag = 0;
      end else if (tk) m_lflag = 1 - m_lflag;
      m_auxp = tk && (m_aux_cnt == 31);
      if (tk) m_aux_cnt = (m_aux_cnt == 31) ? 0 : m_aux_cnt + 1;
    end
  endtask

  task automatic compare();
    chk("R1 line_tick", int'(line_tick), int'(m_cnt == 0));
    chk("R4 line_cnt", int'(line_cnt), m_line);
    chk("R4 in_vblank", int'(in_vblank), m_blank);
    chk("R3 blank_start", int'(blank_start), m_bs);
    chk("R3 vblank_irq", int'(irq), m_bs);
    chk("R9 blank_end", int'(blank_end), m_be);
    chk("R5 frame_cnt", int'(frame_cnt), m_frame);
    chk("R7 field", int'(field), m_field);
    chk("R6 line_flag", int'(lflag), m_lflag);
    chk("R10 aux_tick", int'(aux), m_auxp);
    // frame length from observed ticks, std captured at wrap (R2, R8)
    if (!rst) begin
      if (blank_end) begin
        chk("R2 R8 frame length", ticks_seen, frame_total(frame_std));
        ticks_seen = 0;
        frame_std = std_sel;
      end
      if (line_tick) ticks_seen++;
    end
  endtask

  task automatic cycle();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) cycle();
    rst = 1'b0;
    ticks_seen = 0;
    frame_std = std_sel;
    // R11: cleared state after reset
    chk("R11 frame_cnt", int'(frame_cnt), 0);
    chk("R11 line_cnt", int'(line_cnt), 0);
    chk("R11 flags", int'({in_vblank, field, lflag, blank_start, blank_end, irq, aux}), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5ca1e;
    void'($urandom(seed));
    rst = 1'b1; std_sel = 1'b0; ilace = 2'b11;
    @(negedge clk);
    do_reset(3);
    // directed: 60 Hz frames with interlace on
    for (int i = 0; i < 2000; i++) cycle();
    // directed: switch to 50 Hz mid-frame, single interlace bit
    std_sel = 1'b1; ilace = 2'b01;
    for (int i = 0; i < 2500; i++) cycle();
    ilace = 2'b10;
    for (int i = 0; i < 1000; i++) cycle();
    // mid-frame reset while in 50 Hz
    do_reset(2);
    // first line length after reset (R1)
    ilace = 2'b11;
    for (int i = 0; i < 1500; i++) cycle();
    // random phase
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 299) == 0) std_sel = ~std_sel;
      if ($urandom_range(0, 149) == 0) ilace = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 14999) == 0) do_reset(int'($urandom_range(1, 3)));
      else cycle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule